// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings one or two SDRAM banks out of power-up by issuing a fixed series of mode commands on a single command port. A start pulse launches the series. The block first copies one control word and one timing word into the register pair of each bank. It then issues clock-enable and waits a settling interval. After that it issues precharge-all, two auto-refresh commands and a mode-register load. Last, it latches the refresh-timer count. Each command drives a busy flag for a parameterised number of cycles, and the next command waits until that flag has dropped.

A two-bit target mask goes with every command, one bit per bank. The mask is captured at start, so either bank or both banks can be addressed. When the series completes, the block reports ready and gives a one-cycle done pulse. A stop request in the ready state issues power-down to the same banks and returns the block to its stopped state. The refresh engine, the data path and address multiplexing belong to other blocks.

Top module: `sdram_boot_seq`

## Requirements
- R1: After reset, `ready_o`, `busy_o`, `cmd_valid_o`, `done_o`, `rcnt_o` and all four bank register outputs are zero, and the block is stopped.
- R2: Command codes on `cmd_mode_o` are 0 normal, 1 clock-enable, 2 precharge-all, 3 auto-refresh, 4 load-mode, 5 self-refresh and 6 power-down. A start issues, in order, 1, 2, 3, 3, 4, with each command marked by a one-cycle `cmd_valid_o`.
- R3: Each command raises `busy_o` for CMD_CYC cycles. For auto-refresh the busy time is CMD_CYC*(nrfs+1) cycles. A command is issued only while `busy_o` is low, and it is issued in the cycle after busy falls, so issues are spaced busy-length+1 cycles apart.
- R4: Precharge-all follows clock-enable by SETTLE_CYC+1 cycles, given that SETTLE_CYC >= CMD_CYC.
- R5: `cmd_bank_o` carries the target mask captured at start, and the mask is never zero. Later changes on `bank_sel_i` have no effect. A start while `bank_sel_i` is zero is ignored.
- R6: Both auto-refresh commands carry the captured `nrfs_i` on `cmd_nrfs_o`. Load-mode carries the captured `mrd_i` on `cmd_mrd_o`. Every other command carries zero in both fields.
- R7: On an accepted start, both banks' control outputs take `cfg_ctrl_i` and both timing outputs take `cfg_tim_i`, with identical values.
- R8: `rcnt_o` takes the captured 13-bit refresh count CMD_CYC+1 cycles after the load-mode issue, and `ready_o` rises at the same time. `done_o` pulses for one cycle, one cycle later.
- R9: A start while ready is ignored: no command is issued, and `rcnt_o` and `done_o` do not change.
- R10: A stop while ready issues power-down (6) to the captured banks, and `ready_o` falls. A stop while stopped or mid-sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch the power-up series |
| stop_i | input | 1 | Request power-down from ready |
| bank_sel_i | input | 2 | Target mask, bit 0 bank one, bit 1 bank two |
| nrfs_i | input | NRFS_W | Refresh repeat field (value+1 refreshes) |
| mrd_i | input | MRD_W | Mode register data |
| rcnt_i | input | RCNT_W | Refresh-timer count |
| cfg_ctrl_i | input | CFG_W | Control word for both banks |
| cfg_tim_i | input | CFG_W | Timing word for both banks |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_mode_o | output | 3 | Command code |
| cmd_bank_o | output | 2 | Command target mask |
| cmd_nrfs_o | output | NRFS_W | Refresh field of the command |
| cmd_mrd_o | output | MRD_W | Mode data field of the command |
| busy_o | output | 1 | A command is executing |
| b1_ctrl_o | output | CFG_W | Bank one control register |
| b1_tim_o | output | CFG_W | Bank one timing register |
| b2_ctrl_o | output | CFG_W | Bank two control register |
| b2_tim_o | output | CFG_W | Bank two timing register |
| rcnt_o | output | RCNT_W | Latched refresh count |
| ready_o | output | 1 | Series complete, banks live |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take three things for granted. First, CMD_CYC is at least one, so every command produces visible busy time. Second, SETTLE_CYC is at least CMD_CYC. Third, the power-down command, like every other command, is issued only while busy is low. The stimulus uses a small settle count and a three-cycle command length that satisfy these bounds. Every start it drives carries a nonzero mask, except the one case that checks a zero mask is rejected. The bench changes the mask and stops mid-series only after start has been accepted, which shows the captured values hold.

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq #(
  parameter int SETTLE_CYC = 25000,
  parameter int CMD_CYC    = 4,
  parameter int NRFS_W     = 4,
  parameter int MRD_W      = 13,
  parameter int RCNT_W     = 13,
  parameter int CFG_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        bank_sel_i,
  input  logic [NRFS_W-1:0] nrfs_i,
  input  logic [MRD_W-1:0]  mrd_i,
  input  logic [RCNT_W-1:0] rcnt_i,
  input  logic [CFG_W-1:0]  cfg_ctrl_i,
  input  logic [CFG_W-1:0]  cfg_tim_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_mode_o,
  output logic [1:0]        cmd_bank_o,
  output logic [NRFS_W-1:0] cmd_nrfs_o,
  output logic [MRD_W-1:0]  cmd_mrd_o,
  output logic              busy_o,
  output logic [CFG_W-1:0]  b1_ctrl_o,
  output logic [CFG_W-1:0]  b1_tim_o,
  output logic [CFG_W-1:0]  b2_ctrl_o,
  output logic [CFG_W-1:0]  b2_tim_o,
  output logic [RCNT_W-1:0] rcnt_o,
  output logic              ready_o,
  output logic              done_o
);

  localparam int BUSY_W = $clog2(CMD_CYC * (2 ** NRFS_W) + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);

  localparam logic [2:0] M_CKE  = 3'd1;
  localparam logic [2:0] M_PALL = 3'd2;
  localparam logic [2:0] M_AREF = 3'd3;
  localparam logic [2:0] M_LMR  = 3'd4;
  localparam logic [2:0] M_PDN  = 3'd6;

  typedef enum logic [3:0] {
    ST_STOP, ST_CKE, ST_SETTLE, ST_PALL, ST_AR1, ST_AR2, ST_LMR, ST_RCNT, ST_READY
  } st_t;

  st_t               st;
  logic [BUSY_W-1:0] busy_cnt;
  logic [SET_W-1:0]  set_cnt;
  logic [1:0]        bank_q;
  logic [NRFS_W-1:0] nrfs_q;
  logic [MRD_W-1:0]  mrd_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic              rcnt_wr;
  logic              idle;
  logic [BUSY_W-1:0] aref_len;

  assign idle     = (busy_cnt == '0);
  assign busy_o   = !idle;
  assign ready_o  = (st == ST_READY);
  assign aref_len = BUSY_W'(CMD_CYC * (int'(nrfs_q) + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_STOP;
      busy_cnt    <= '0;
      set_cnt     <= '0;
      bank_q      <= '0;
      nrfs_q      <= '0;
      mrd_q       <= '0;
      rcnt_q      <= '0;
      rcnt_wr     <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_mode_o  <= '0;
      cmd_bank_o  <= '0;
      cmd_nrfs_o  <= '0;
      cmd_mrd_o   <= '0;
      b1_ctrl_o   <= '0;
      b1_tim_o    <= '0;
      b2_ctrl_o   <= '0;
      b2_tim_o    <= '0;
      rcnt_o      <= '0;
      done_o      <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      rcnt_wr     <= 1'b0;
      done_o      <= rcnt_wr;
      if (!idle) busy_cnt <= busy_cnt - 1'b1;
      case (st)
        ST_STOP: if (start_i && bank_sel_i != 2'b00) begin
          bank_q    <= bank_sel_i;
          nrfs_q    <= nrfs_i;
          mrd_q     <= mrd_i;
          rcnt_q    <= rcnt_i;
          b1_ctrl_o <= cfg_ctrl_i;
          b1_tim_o  <= cfg_tim_i;
          b2_ctrl_o <= cfg_ctrl_i;
          b2_tim_o  <= cfg_tim_i;
          st        <= ST_CKE;
        end
        ST_CKE: if (idle) begin
          cmd_valid_o <= 1'b1;
          cmd_mode_o  <= M_CKE;
          cmd_bank_o  <= bank_q;
          cmd_nrfs_o  <= '0;
          cmd_mrd_o   <= '0;
          busy_cnt    <= BUSY_W'(CMD_CYC);
          set_cnt     <= '0;
          st          <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (set_cnt == SET_W'(SETTLE_CYC - 1)) st <= ST_PALL;
          else set_cnt <= set_cnt + 1'b1;
        end
        ST_PALL: if (idle) begin
          cmd_valid_o <= 1'b1;
          cmd_mode_o  <= M_PALL;
          cmd_bank_o  <= bank_q;
          cmd_nrfs_o  <= '0;
          cmd_mrd_o   <= '0;
          busy_cnt    <= BUSY_W'(CMD_CYC);
          st          <= ST_AR1;
        end
        ST_AR1, ST_AR2: if (idle) begin
          cmd_valid_o <= 1'b1;
          cmd_mode_o  <= M_AREF;
          cmd_bank_o  <= bank_q;
          cmd_nrfs_o  <= nrfs_q;
          cmd_mrd_o   <= '0;
          busy_cnt    <= aref_len;
          st          <= (st == ST_AR1) ? ST_AR2 : ST_LMR;
        end
        ST_LMR: if (idle) begin
          cmd_valid_o <= 1'b1;
          cmd_mode_o  <= M_LMR;
          cmd_bank_o  <= bank_q;
          cmd_nrfs_o  <= '0;
          cmd_mrd_o   <= mrd_q;
          busy_cnt    <= BUSY_W'(CMD_CYC);
          st          <= ST_RCNT;
        end
        ST_RCNT: if (idle) begin
          rcnt_o  <= rcnt_q;
          rcnt_wr <= 1'b1;
          st      <= ST_READY;
        end
        ST_READY: if (stop_i && idle) begin
          cmd_valid_o <= 1'b1;
          cmd_mode_o  <= M_PDN;
          cmd_bank_o  <= bank_q;
          cmd_nrfs_o  <= '0;
          cmd_mrd_o   <= '0;
          busy_cnt    <= BUSY_W'(CMD_CYC);
          st          <= ST_STOP;
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  a_r3_issue_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(!busy_o));
  a_r3_busy_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o);
  a_r5_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_bank_o != 2'b00);
  a_r6_nrfs_only_aref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_mode_o != M_AREF) |-> cmd_nrfs_o == '0);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && $stable(rcnt_o)));
  a_r10_pdn_leaves_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_mode_o == M_PDN) |-> !ready_o);
  a_r7_banks_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_ctrl_o == b2_ctrl_o) && (b1_tim_o == b2_tim_o));

endmodule

// File: tb/tb_sdram_boot_seq.sv
module tb_sdram_boot_seq;
  localparam int S = 20;
  localparam int C = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] bank_sel_i = '0;
  logic [3:0] nrfs_i = '0;
  logic [12:0] mrd_i = '0, rcnt_i = '0;
  logic [15:0] cfg_ctrl_i = '0, cfg_tim_i = '0;
  logic cmd_valid_o, busy_o, ready_o, done_o;
  logic [2:0] cmd_mode_o;
  logic [1:0] cmd_bank_o;
  logic [3:0] cmd_nrfs_o;
  logic [12:0] cmd_mrd_o, rcnt_o;
  logic [15:0] b1_ctrl_o, b1_tim_o, b2_ctrl_o, b2_tim_o;

  sdram_boot_seq #(.SETTLE_CYC(S), .CMD_CYC(C), .NRFS_W(4), .MRD_W(13),
                   .RCNT_W(13), .CFG_W(16)) dut (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_n = 0, done_n = 0, done_cyc = 0;
  int cyc_log [64];
  logic [2:0] mode_log [64];
  logic [1:0] bank_log [64];
  logic [3:0] nrfs_log [64];
  logic [12:0] mrd_log [64];
  always @(negedge clk) begin
    if (cmd_valid_o && log_n < 64) begin
      cyc_log[log_n] = cyc; mode_log[log_n] = cmd_mode_o; bank_log[log_n] = cmd_bank_o;
      nrfs_log[log_n] = cmd_nrfs_o; mrd_log[log_n] = cmd_mrd_o;
      log_n = log_n + 1;
    end
    if (done_o) begin done_n = done_n + 1; done_cyc = cyc; end
  end

  int total = 0, bad = 0;
  bit ended = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // bank[63:62] nrfs[61:58] mrd[57:45] rcnt[44:32] ctrl[31:16] tim[15:0]
  localparam logic [63:0] VEC [4] = '{
    {2'b01, 4'd1,  13'h0230, 13'h0603, 16'h1A2B, 16'h3C4D},
    {2'b10, 4'd0,  13'h1FFF, 13'h1FFF, 16'hFFFF, 16'h0001},
    {2'b11, 4'd15, 13'h0000, 13'h0001, 16'h0000, 16'h8000},
    {2'b11, 4'd3,  13'h0A5A, 13'h1000, 16'h5555, 16'hAAAA}
  };

  task automatic run_vec(logic [63:0] v, bit mid_stop);
    int base, dn, n, t;
    bit modes_ok, bank_ok, fld_ok, gap_ok;
    logic [2:0] em [5];
    int eg [4];
    em = '{3'd1, 3'd2, 3'd3, 3'd3, 3'd4};
    base = log_n; dn = done_n; n = int'(v[61:58]);
    eg = '{S + 1, C + 1, C * (n + 1) + 1, C * (n + 1) + 1};
    bank_sel_i = v[63:62]; nrfs_i = v[61:58]; mrd_i = v[57:45]; rcnt_i = v[44:32];
    cfg_ctrl_i = v[31:16]; cfg_tim_i = v[15:0];
    start_i = 1'b1; cycles(1); start_i = 1'b0;
    bank_sel_i = 2'b00; nrfs_i = ~v[61:58]; mrd_i = ~v[57:45]; rcnt_i = ~v[44:32];
    if (mid_stop) begin cycles(3); stop_i = 1'b1; cycles(1); stop_i = 1'b0; end
    t = 0;
    while (done_n == dn && t < 2000) begin cycles(1); t++; end
    chk(done_n != dn, "R8", "done pulse seen", done_n - dn, 1);
    chk(log_n - base == 5, "R2", "command count", log_n - base, 5);
    modes_ok = 1; bank_ok = 1; fld_ok = 1; gap_ok = 1;
    for (int i = 0; i < 5; i++) begin
      if (mode_log[base+i] != em[i]) modes_ok = 0;
      if (bank_log[base+i] != v[63:62]) bank_ok = 0;
      if (nrfs_log[base+i] != ((em[i] == 3'd3) ? v[61:58] : 4'd0)) fld_ok = 0;
      if (mrd_log[base+i] != ((em[i] == 3'd4) ? v[57:45] : 13'd0)) fld_ok = 0;
      if (i < 4 && cyc_log[base+i+1] - cyc_log[base+i] != eg[i]) gap_ok = 0;
    end
    chk(modes_ok, "R2", "mode order", mode_log[base+1], 2);
    chk(bank_ok, "R5", "latched bank mask", bank_log[base], int'(v[63:62]));
    chk(fld_ok, "R6", "nrfs/mrd fields", mrd_log[base+4], int'(v[57:45]));
    chk(cyc_log[base+1] - cyc_log[base] == S + 1, "R4", "settle gap",
        cyc_log[base+1] - cyc_log[base], S + 1);
    chk(gap_ok, "R3", "busy spacing", cyc_log[base+3] - cyc_log[base+2], C * (n + 1) + 1);
    chk(done_cyc - cyc_log[base+4] == C + 2, "R8", "done timing",
        done_cyc - cyc_log[base+4], C + 2);
    chk(rcnt_o == v[44:32] && ready_o, "R8", "rcnt and ready", int'(rcnt_o), int'(v[44:32]));
    chk(b1_ctrl_o == v[31:16] && b2_ctrl_o == v[31:16] && b1_tim_o == v[15:0]
        && b2_tim_o == v[15:0], "R7", "bank registers", int'(b2_tim_o), int'(v[15:0]));
  endtask

  task automatic stop_ready(logic [1:0] bank);
    int base;
    base = log_n;
    stop_i = 1'b1; cycles(1); stop_i = 1'b0; cycles(1);
    chk(log_n - base == 1 && mode_log[base] == 3'd6 && bank_log[base] == bank,
        "R10", "power-down issue", int'(mode_log[base]), 6);
    chk(!ready_o, "R10", "ready dropped", int'(ready_o), 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    finish_run();
  end

  initial begin
    int base, dn;
    cycles(3);
    chk(!ready_o && !busy_o && !cmd_valid_o && !done_o && rcnt_o == 0 &&
        b1_ctrl_o == 0 && b2_tim_o == 0, "R1", "reset outputs", int'(ready_o), 0);
    rst_n = 1'b1; cycles(2);

    base = log_n;
    stop_i = 1'b1; cycles(1); stop_i = 1'b0; cycles(5);
    chk(log_n == base && !ready_o, "R10", "stop while stopped ignored", log_n - base, 0);

    bank_sel_i = 2'b00; start_i = 1'b1; cycles(1); start_i = 1'b0; cycles(5);
    chk(log_n == base && !ready_o, "R5", "zero mask start ignored", log_n - base, 0);

    for (int k = 0; k < 4; k++) begin
      run_vec(VEC[k], 1'b0);
      stop_ready(VEC[k][63:62]);
    end

    run_vec(VEC[3], 1'b1);
    base = log_n; dn = done_n;
    bank_sel_i = 2'b01; rcnt_i = 13'h0777; start_i = 1'b1; cycles(1); start_i = 1'b0;
    cycles(12);
    chk(log_n == base && done_n == dn && rcnt_o == VEC[3][44:32] && ready_o,
        "R9", "start while ready ignored", int'(rcnt_o), int'(VEC[3][44:32]));
    stop_ready(VEC[3][63:62]);

    cycles(5);
    finish_run();
  end
endmodule